// File: doc/BRIEF.md
# Byte Reprogramming Sequencer for a Nonvolatile Array

This block carries out the internal reprogramming of a 256-byte nonvolatile store after the serial bus front-end has taken in a complete write request. The front-end hands over an address, a data byte and a qualifier for whole-array erase in a single-cycle request. The sequencer then runs an erase phase, which sets the target byte to all ones. It follows this with a write phase, which clears exactly the bits that are zero in the data byte. Each phase lasts a fixed number of clock cycles set by a parameter. By default each phase is half of a 10 ms nominal cycle.

Phases that would change nothing are left out. If the stored byte already reads FF, the erase phase is skipped. If the data byte has no zero bit, the write phase is skipped. The front-end can cut an active cycle short through an abort input, which it raises when an entry select arrives while busy. While busy is high, the front-end refuses read selects. When the whole-array qualifier comes with address 0 and data FF, the sequencer erases every location. For a set number of cycles after reset, requests are dropped.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, busy_o is low and every address reads 8'hFF on the read port.
- R2: When the stored byte is not FF and the data byte is not FF, busy_o stays high for ERASE_CYC + WRITE_CYC cycles. At the end the byte reads as the data byte.
- R3: When the stored byte already reads FF, the erase phase is skipped and busy_o stays high for WRITE_CYC cycles only.
- R4: When the data byte is FF, the write phase is skipped: busy_o stays high for ERASE_CYC cycles and the byte ends as FF. When both phases are skipped, busy_o never rises and the array is unchanged.
- R5: busy_o rises in the clock cycle after an accepted request. A single cycle never keeps it high for more than ERASE_CYC + WRITE_CYC cycles.
- R6: abort_i sampled high while busy drops busy_o at the next clock. An abort during erase leaves the target byte unchanged. An abort during write leaves it at FF.
- R7: A request with bulk_i high, address 0 and data FF sets every location to FF after ERASE_CYC busy cycles. With bulk_i high and any other address or data, the request is an ordinary single-byte reprogramming.
- R8: A request sampled within the first POR_CYC clock edges after reset release is dropped: busy_o does not rise and the array is unchanged.
- R9: A request sampled while busy_o is high is ignored and does not alter the array.
- R10: rd_data_o shows the stored byte at rd_addr_i in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle reprogramming request |
| req_addr_i | input | 8 | Target byte address |
| req_data_i | input | 8 | Data byte to store |
| bulk_i | input | 1 | Whole-array erase qualifier |
| abort_i | input | 1 | Abort of the active cycle |
| busy_o | output | 1 | High while a cycle runs |
| rd_addr_i | input | 8 | Read port address |
| rd_data_o | output | 8 | Read port data |

## Verification
The assertions assume that req_i is a single-cycle pulse with its address, data and qualifier valid in that same cycle. They also assume that abort_i only matters while busy_o is high. The stimulus drives every input at the falling clock edge and holds it steady through the next rising edge. It raises req_i for exactly one cycle per request. It raises abort_i only at chosen points inside the erase phase or the write phase. Requests are deliberately placed inside the power-on interval and inside an active cycle. This tests that both are dropped without tripping any property.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr_i) t_d.cnt = '0;
        else       t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign last_o = (t_q.cnt == limit_i - 1'b1);

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (t_q.cnt < limit_i)); // R5
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             clr_all_i,
    input  logic [AW-1:0]    chk_addr_i,
    output logic [WIDTH-1:0] chk_data_o,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [WIDTH-1:0] row_d, row_q;
        always_comb begin
            row_d = row_q;
            if (clr_all_i)                               row_d = '1;
            else if (wr_en_i && wr_addr_i == AW'(g))     row_d = wr_data_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q <= '1;
            else        row_q <= row_d;
        end
        assign cells[g] = row_q;
    end

    assign chk_data_o = cells[chk_addr_i];
    assign rd_data_o  = cells[rd_addr_i];
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
    import nvm_prog_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int WIDTH     = 8,
    parameter int NOM_CYC   = 500000,
    parameter int ERASE_CYC = NOM_CYC / 2,
    parameter int WRITE_CYC = NOM_CYC / 2,
    parameter int POR_CYC   = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic [$clog2(DEPTH)-1:0] req_addr_i,
    input  logic [WIDTH-1:0]         req_data_i,
    input  logic                     bulk_i,
    input  logic                     abort_i,
    output logic                     busy_o,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
    output logic [WIDTH-1:0]         rd_data_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int MAXP  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CW    = $clog2(MAXP + 1);
    localparam int GW    = $clog2(POR_CYC + 1);
    localparam int TOT   = ERASE_CYC + WRITE_CYC;
    localparam int RW    = $clog2(TOT + 1);
    localparam logic [GW-1:0] POR_LIM = GW'(POR_CYC);

    typedef struct packed {
        phase_e           st;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
        logic             bulk;
        logic             need_wr;
        logic [GW-1:0]    guard;
    } seq_t;

    seq_t s_d, s_q;

    logic             arr_we, arr_clr, tmr_clr, tmr_last, guard_done, bulk_hit;
    logic [WIDTH-1:0] arr_wdata, cur_byte;
    logic [CW-1:0]    tmr_limit;

    assign guard_done = (s_q.guard == POR_LIM);
    assign bulk_hit   = bulk_i && (req_addr_i == '0) && (req_data_i == '1);
    assign tmr_limit  = (s_q.st == PH_ERASE) ? CW'(ERASE_CYC) : CW'(WRITE_CYC);
    assign arr_wdata  = (s_q.st == PH_ERASE) ? '1 : s_q.data;

    always_comb begin
        s_d     = s_q;
        arr_we  = 1'b0;
        arr_clr = 1'b0;
        tmr_clr = 1'b1;
        if (!guard_done) s_d.guard = s_q.guard + 1'b1;
        case (s_q.st)
            PH_IDLE: begin
                if (req_i && guard_done) begin
                    s_d.addr    = req_addr_i;
                    s_d.data    = req_data_i;
                    s_d.bulk    = bulk_hit;
                    s_d.need_wr = (req_data_i != '1) && !bulk_hit;
                    if (bulk_hit || cur_byte != '1) s_d.st = PH_ERASE;
                    else if (req_data_i != '1)      s_d.st = PH_WRITE;
                end
            end
            PH_ERASE: begin
                if (abort_i) begin
                    s_d.st = PH_IDLE;
                end else if (tmr_last) begin
                    arr_clr = s_q.bulk;
                    arr_we  = !s_q.bulk;
                    s_d.st  = s_q.need_wr ? PH_WRITE : PH_IDLE;
                end else begin
                    tmr_clr = 1'b0;
                end
            end
            PH_WRITE: begin
                if (abort_i) begin
                    s_d.st = PH_IDLE;
                end else if (tmr_last) begin
                    arr_we = 1'b1;
                    s_d.st = PH_IDLE;
                end else begin
                    tmr_clr = 1'b0;
                end
            end
            default: s_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PH_IDLE, addr: '0, data: '0, bulk: 1'b0,
                     need_wr: 1'b0, guard: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st != PH_IDLE);

    nvm_phase_timer #(.CW(CW)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .limit_i (tmr_limit),
        .last_o  (tmr_last)
    );

    nvm_cell_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) array_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (arr_we),
        .wr_addr_i  (s_q.addr),
        .wr_data_i  (arr_wdata),
        .clr_all_i  (arr_clr),
        .chk_addr_i (req_addr_i),
        .chk_data_o (cur_byte),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RW'(TOT))); // R5
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> !busy_o); // R6
    AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_done && !busy_o && req_i) |=> !busy_o); // R8
    AST_BUSY_REQ_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> $stable(s_q.addr) && $stable(s_q.data)); // R9
    AST_BULK_ONLY_FF0: assert property (@(posedge clk) disable iff (!rst_n)
        arr_clr |-> (s_q.addr == '0 && s_q.data == '1)); // R7
endmodule

// File: tb/nvm_prog_seq_tb_top.sv
module nvm_prog_seq_tb_top;
    localparam int CLK_PER = 10;
    localparam int EC  = 5;
    localparam int WC  = 7;
    localparam int PC  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, bulk = 1'b0, abort = 1'b0;
    logic [7:0] ra = '0, rdat = '0, rdaddr = '0;
    logic       busy;
    logic [7:0] rd_data;

    int total = 0, bad = 0, cyc = 0;
    int mem [256];
    int phq [$];
    int rem = 0, m_addr = 0, m_data = 0, edges = 0;

    always #(CLK_PER/2) clk = ~clk;

    nvm_prog_seq #(.ERASE_CYC(EC), .WRITE_CYC(WC), .POR_CYC(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(ra), .req_data_i(rdat),
        .bulk_i(bulk), .abort_i(abort), .busy_o(busy),
        .rd_addr_i(rdaddr), .rd_data_o(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // reference model: phase codes 1=erase byte, 2=write byte, 3=erase all
    task automatic model_edge();
        bit ok = (edges >= PC);
        edges++;
        if (phq.size() != 0) begin
            if (abort) begin
                phq.delete();
            end else begin
                rem--;
                if (rem == 0) begin
                    case (phq[0])
                        1: mem[m_addr] = 8'hFF;
                        2: mem[m_addr] = mem[m_addr] & m_data;
                        default: foreach (mem[i]) mem[i] = 8'hFF;
                    endcase
                    void'(phq.pop_front());
                    if (phq.size() != 0) rem = (phq[0] == 2) ? WC : EC;
                end
            end
        end else if (req && ok) begin
            m_addr = ra; m_data = rdat;
            if (bulk && ra == 0 && rdat == 8'hFF) phq.push_back(3);
            else begin
                if (mem[ra] != 8'hFF) phq.push_back(1);
                if (rdat != 8'hFF)    phq.push_back(2);
            end
            if (phq.size() != 0) rem = (phq[0] == 2) ? WC : EC;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R5 busy vs model", busy, (phq.size() != 0));
        check("R10 read vs model", rd_data, mem[rdaddr]);
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        rdaddr = 8'(a);
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic request(input int a, input int d, input bit b, output int cycles);
        ra = 8'(a); rdat = 8'(d); bulk = b; req = 1'b1;
        tick();
        req = 1'b0; bulk = 1'b0;
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            tick();
        end
    endtask

    initial begin
        int n;
        foreach (mem[i]) mem[i] = 8'hFF;
        #(CLK_PER * 3);
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        rd("R1 reset byte 0", 0, 8'hFF);
        rd("R1 reset byte 255", 255, 8'hFF);
        rst_n = 1'b1;

        // R8: request during the blocking interval
        ra = 8'd3; rdat = 8'h5A; req = 1'b1;
        tick();
        req = 1'b0;
        check("R8 busy after early request", busy, 0);
        for (int i = 0; i < PC; i++) tick();
        check("R8 busy still low", busy, 0);
        rd("R8 byte unchanged", 3, 8'hFF);

        // R3: fresh byte, erase skipped
        request(3, 8'h5A, 1'b0, n);
        check("R3 busy length write only", n, WC);
        rd("R3 byte stored", 3, 8'h5A);

        // R2: full erase and write
        request(3, 8'hC3, 1'b0, n);
        check("R2 busy length erase+write", n, EC + WC);
        rd("R2 byte stored", 3, 8'hC3);

        // R4: data FF, write skipped
        request(3, 8'hFF, 1'b0, n);
        check("R4 busy length erase only", n, EC);
        rd("R4 byte erased", 3, 8'hFF);
        request(3, 8'hFF, 1'b0, n);
        check("R4 both skipped no busy", n, 0);
        rd("R4 byte unchanged", 3, 8'hFF);

        // R9: request while busy
        ra = 8'd10; rdat = 8'h00; req = 1'b1;
        tick();
        ra = 8'd11; rdat = 8'h00;
        tick();
        req = 1'b0;
        while (busy) tick();
        rd("R9 ignored address untouched", 11, 8'hFF);
        rd("R9 first request done", 10, 8'h00);

        // R6: abort during erase
        ra = 8'd10; rdat = 8'h77; req = 1'b1;
        tick();
        req = 1'b0;
        tick(); tick();
        abort = 1'b1;
        tick();
        abort = 1'b0;
        check("R6 busy low after abort in erase", busy, 0);
        rd("R6 byte unchanged after erase abort", 10, 8'h00);

        // R6: abort during write
        ra = 8'd10; rdat = 8'h11; req = 1'b1;
        tick();
        req = 1'b0;
        for (int i = 0; i < EC + 2; i++) tick();
        abort = 1'b1;
        tick();
        abort = 1'b0;
        check("R6 busy low after abort in write", busy, 0);
        rd("R6 byte erased after write abort", 10, 8'hFF);

        // R7: bulk qualifier with non-matching request is ordinary
        request(20, 8'h3C, 1'b0, n);
        request(200, 8'h81, 1'b0, n);
        request(0, 8'h00, 1'b1, n);
        check("R7 bulk with data 00 is ordinary", n, WC);
        rd("R7 byte 0 written", 0, 8'h00);
        rd("R7 other byte kept", 20, 8'h3C);
        request(0, 8'hFF, 1'b1, n);
        check("R7 total erase length", n, EC);
        rd("R7 byte 0 erased", 0, 8'hFF);
        rd("R7 byte 20 erased", 20, 8'hFF);
        rd("R7 byte 200 erased", 200, 8'hFF);

        for (int i = 0; i < 3; i++) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule